// File: doc/BRIEF.md
# Up/Down Auto-Reload Counter/Timer

This block is a counter/timer with automatic reload, controlled through a small register port. It holds a count and a reload value, both `CNT_W` bits wide. The count advances on cycles where the selected tick is present. The tick is either a tick-enable input, usually driven by a shared prescaler, or a synchronized falling edge on an external count pin. When the count wraps, the block reloads itself, sets a sticky wrap flag and flips a toggle bit. The toggle bit behaves as one extra high-order count bit.

The count direction depends on a control bit. When that bit is clear, the block counts up and the external control pin acts as a reload trigger. When that bit is set, the level of the same pin selects up or down counting. Counting up, the wrap point is all ones, and the counter then loads the reload value. Counting down, the wrap point is a match with the reload value, and the counter then loads all ones. Software reads and writes three registers: control at address 0, count at address 1 and reload at address 2. Address 3 reads as zero.

Top module: `updown_reload_timer`

## Requirements
- R1: After reset, the count, the reload value and every control bit are 0, and `irq_o` and `tog_o` are 0.
- R2: The count changes only when run (control bit 0) is 1 and capture select (control bit 5) is 0. Clearing run, or setting capture select, freezes the count.
- R3: Counting up, a tick while the count is all ones loads the reload value and sets the wrap flag (control bit 6).
- R4: Counting down, a tick while the count equals the reload value loads all ones and sets the wrap flag.
- R5: With external enable (bit 1) at 1 and direction control (bit 2) at 0, a synchronized falling edge on `ex_pin` loads the reload value and leaves the wrap flag unchanged.
- R6: With direction control at 1, a synchronized `ex_pin` level of 1 selects up counting and 0 selects down counting. An `ex_pin` edge then causes no reload.
- R7: The toggle flag (control bit 7, also on `tog_o`) inverts on every wrap and never drives `irq_o`.
- R8: With count source (bit 3) at 1, the count advances once per synchronized falling edge of `cnt_pin`, and `tick_en` is ignored.
- R9: The wrap flag stays set until a control write clears it. A control write of 1 to the flag sets it. `irq_o` equals the wrap flag AND irq enable (bit 4).
- R10: When an `ex_pin` reload and an up wrap fall in the same cycle, the count takes the reload value once, the wrap flag is set, and the toggle flag inverts exactly once.
- R11: A software write to the count register wins over counting in the same cycle. No wrap is reported for that cycle.
- R12: Both external pins pass through a two-flop synchronizer. A pin change takes effect at the third rising clock edge after the pin changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_en | input | 1 | Prescaled count tick used when count source is 0 |
| ex_pin | input | 1 | External reload trigger or direction select |
| cnt_pin | input | 1 | External count input used when count source is 1 |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address: 0 control, 1 count, 2 reload |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data for `reg_addr` (combinational) |
| count_o | output | 16 | Current count |
| tog_o | output | 1 | Toggle flag (seventeenth count bit) |
| irq_o | output | 1 | Interrupt request |

## Verification
The collision the bench targets is an external-pin reload that lands on the same edge as an up-count wrap from all ones. To provoke it, the bench preloads the count to all ones with ticks held off. It then drops `ex_pin` and raises `tick_en` for exactly the edge at which the synchronized falling edge is consumed. The result passes only if the count holds the reload value once, the flag is set and the toggle bit differs from its earlier value by a single inversion. A second collision, a software count write made during a running tick, is judged by checking that the written value, and not its successor, appears after the edge.

// File: rtl/urt_pkg.sv
package urt_pkg;

   localparam int unsigned CTL_W = 8;

   localparam logic [1:0] A_CTL = 2'd0;
   localparam logic [1:0] A_CNT = 2'd1;
   localparam logic [1:0] A_REL = 2'd2;

   typedef struct packed {
      logic tog;      // bit 7
      logic flag;     // bit 6
      logic cap_sel;  // bit 5
      logic irq_en;   // bit 4
      logic src_ext;  // bit 3
      logic dir_ctl;  // bit 2
      logic ext_en;   // bit 1
      logic run;      // bit 0
   } ctl_t;

endpackage

// File: rtl/urt_pin_sync.sv
module urt_pin_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pin_i,
   output logic level_o,
   output logic fall_o
);

   if (STAGES < 1) begin : g_bad_stages
      $error("urt_pin_sync: STAGES must be at least 1");
   end

   logic [STAGES-1:0] sr_q;
   logic              prev_q;

   if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) sr_q <= '0;
         else        sr_q <= pin_i;
      end
   end else begin : g_chain
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) sr_q <= '0;
         else        sr_q <= {sr_q[STAGES-2:0], pin_i};
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= 1'b0;
      else        prev_q <= sr_q[STAGES-1];
   end

   assign level_o = sr_q[STAGES-1];
   assign fall_o  = prev_q & ~sr_q[STAGES-1];

   // R12: a detected fall is always followed by a low level one cycle later
   p_fall_low_r12: assert property (@(posedge clk) disable iff (!rst_n)
      fall_o |=> !prev_q);

endmodule

// File: rtl/urt_count_core.sv
module urt_count_core #(
   parameter int unsigned W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         tick_i,
   input  logic         up_i,
   input  logic         xreload_i,
   input  logic [W-1:0] reload_i,
   input  logic         ld_en_i,
   input  logic [W-1:0] ld_val_i,
   output logic [W-1:0] cnt_o,
   output logic         evt_o
);

   localparam logic [W-1:0] ONES = '1;
   localparam logic [W-1:0] ONE  = W'(1);

   if (W < 2) begin : g_bad_w
      $error("urt_count_core: W must be at least 2");
   end

   logic [W-1:0] cnt_q, cnt_d;
   logic         wrap_hit, evt;

   assign wrap_hit = up_i ? (cnt_q == ONES) : (cnt_q == reload_i);
   assign evt      = tick_i & ~ld_en_i & wrap_hit;

   always_comb begin
      cnt_d = cnt_q;
      if (ld_en_i)        cnt_d = ld_val_i;
      else if (evt)       cnt_d = up_i ? reload_i : ONES;
      else if (xreload_i) cnt_d = reload_i;
      else if (tick_i)    cnt_d = up_i ? cnt_q + ONE : cnt_q - ONE;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cnt_q <= '0;
      else        cnt_q <= cnt_d;
   end

   assign cnt_o = cnt_q;
   assign evt_o = evt;

   // R3: up wrap lands on the reload value
   p_up_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (evt_o && up_i) |=> cnt_o == $past(reload_i));
   // R4: down wrap lands on all ones
   p_down_wrap_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (evt_o && !up_i) |=> cnt_o == ONES);
   // R2: no tick, no reload, no load -> count holds
   p_idle_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (!tick_i && !xreload_i && !ld_en_i) |=> $stable(cnt_o));
   // R11: a software load always lands
   p_load_wins_r11: assert property (@(posedge clk) disable iff (!rst_n)
      ld_en_i |=> cnt_o == $past(ld_val_i));

endmodule

// File: rtl/updown_reload_timer.sv
module updown_reload_timer
   import urt_pkg::*;
#(
   parameter int unsigned CNT_W       = 16,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick_en,
   input  logic             ex_pin,
   input  logic             cnt_pin,
   input  logic             reg_wr,
   input  logic [1:0]       reg_addr,
   input  logic [CNT_W-1:0] reg_wdata,
   output logic [CNT_W-1:0] reg_rdata,
   output logic [CNT_W-1:0] count_o,
   output logic             tog_o,
   output logic             irq_o
);

   if (CNT_W < CTL_W) begin : g_bad_width
      $error("updown_reload_timer: CNT_W must hold the control register");
   end

   ctl_t             ctl_q, ctl_d;
   logic [CNT_W-1:0] rel_q;
   logic [CNT_W-1:0] cnt;
   logic             ex_lvl, ex_fall, cp_lvl, cp_fall;
   logic             active, tick, up, xreload, evt;
   logic             wr_ctl, wr_cnt, wr_rel;

   urt_pin_sync #(.STAGES(SYNC_STAGES)) u_ex_sync (
      .clk(clk), .rst_n(rst_n), .pin_i(ex_pin),
      .level_o(ex_lvl), .fall_o(ex_fall));

   urt_pin_sync #(.STAGES(SYNC_STAGES)) u_cp_sync (
      .clk(clk), .rst_n(rst_n), .pin_i(cnt_pin),
      .level_o(cp_lvl), .fall_o(cp_fall));

   assign wr_ctl = reg_wr && (reg_addr == A_CTL);
   assign wr_cnt = reg_wr && (reg_addr == A_CNT);
   assign wr_rel = reg_wr && (reg_addr == A_REL);

   assign active  = ctl_q.run & ~ctl_q.cap_sel;
   assign tick    = active & (ctl_q.src_ext ? cp_fall : tick_en);
   assign up      = ctl_q.dir_ctl ? ex_lvl : 1'b1;
   assign xreload = active & ctl_q.ext_en & ~ctl_q.dir_ctl & ex_fall & ~wr_cnt;

   urt_count_core #(.W(CNT_W)) u_core (
      .clk(clk), .rst_n(rst_n),
      .tick_i(tick), .up_i(up), .xreload_i(xreload),
      .reload_i(rel_q), .ld_en_i(wr_cnt), .ld_val_i(reg_wdata),
      .cnt_o(cnt), .evt_o(evt));

   always_comb begin
      ctl_d = wr_ctl ? ctl_t'(reg_wdata[CTL_W-1:0]) : ctl_q;
      ctl_d.flag = ctl_d.flag | evt;
      ctl_d.tog  = ctl_d.tog ^ evt;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctl_q <= '0;
         rel_q <= '0;
      end else begin
         ctl_q <= ctl_d;
         if (wr_rel) rel_q <= reg_wdata;
      end
   end

   always_comb begin
      case (reg_addr)
         A_CTL:   reg_rdata = CNT_W'(ctl_q);
         A_CNT:   reg_rdata = cnt;
         A_REL:   reg_rdata = rel_q;
         default: reg_rdata = '0;
      endcase
   end

   assign count_o = cnt;
   assign tog_o   = ctl_q.tog;
   assign irq_o   = ctl_q.flag & ctl_q.irq_en;

   // R7: every wrap inverts the toggle flag exactly once
   p_tog_flip_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (evt && !wr_ctl) |=> tog_o != $past(tog_o));
   // R9: wrap flag is sticky without a control write
   p_flag_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl_q.flag && !wr_ctl) |=> ctl_q.flag);
   // R5: pin reload without a wrap loads the reload value, flag untouched
   p_xreload_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (xreload && !evt && !wr_ctl) |=> (cnt == $past(rel_q)) && (ctl_q.flag == $past(ctl_q.flag)));
   // R6: in direction mode with no tick the pin cannot move the count
   p_dir_noreload_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl_q.dir_ctl && !tick && !wr_cnt) |=> $stable(cnt));
   // R2: frozen while stopped
   p_frozen_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (!active && !wr_cnt) |=> $stable(cnt));

endmodule

// File: tb/sim_updown_reload_timer.sv
module sim_updown_reload_timer;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        tick_en = 1'b0, ex_pin = 1'b1, cnt_pin = 1'b0;
   logic        reg_wr = 1'b0;
   logic [1:0]  reg_addr = 2'd0;
   logic [15:0] reg_wdata = 16'd0;
   logic [15:0] reg_rdata, count_o;
   logic        tog_o, irq_o;

   int n_chk = 0, n_fail = 0;

   always #4 clk = ~clk;

   updown_reload_timer u0 (
      .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .ex_pin(ex_pin),
      .cnt_pin(cnt_pin), .reg_wr(reg_wr), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .count_o(count_o),
      .tog_o(tog_o), .irq_o(irq_o));

   // control bit values
   localparam logic [15:0] C_RUN = 16'h01, C_XEN = 16'h02, C_DIR = 16'h04,
                           C_SRC = 16'h08, C_IEN = 16'h10, C_CAP = 16'h20,
                           C_FLG = 16'h40, C_TOG = 16'h80;

   // ---------------- behavioural reference ----------------
   logic [15:0] m_cnt = 0, m_rel = 0;
   logic [7:0]  m_ctl = 0;
   bit          qe[$] = '{0, 0, 0};
   bit          qc[$] = '{0, 0, 0};

   always @(posedge clk) begin
      if (!rst_n) begin
         m_cnt = 0; m_rel = 0; m_ctl = 0;
         qe = '{0, 0, 0}; qc = '{0, 0, 0};
      end else begin
         bit act, tk, upd, cw, ev, xr, exf, cpf;
         logic [7:0] nctl;
         exf = qe[2] && !qe[1];
         cpf = qc[2] && !qc[1];
         act = m_ctl[0] && !m_ctl[5];
         tk  = act && (m_ctl[3] ? cpf : tick_en);
         upd = m_ctl[2] ? qe[1] : 1'b1;
         cw  = reg_wr && reg_addr == 2'd1;
         ev  = tk && !cw && (upd ? (m_cnt == 16'hFFFF) : (m_cnt == m_rel));
         xr  = act && m_ctl[1] && !m_ctl[2] && exf && !cw;
         nctl = (reg_wr && reg_addr == 2'd0) ? reg_wdata[7:0] : m_ctl;
         if (ev) begin nctl[6] = 1'b1; nctl[7] = !nctl[7]; end
         if (cw)      m_cnt = reg_wdata;
         else if (ev) m_cnt = upd ? m_rel : 16'hFFFF;
         else if (xr) m_cnt = m_rel;
         else if (tk) m_cnt = upd ? m_cnt + 16'd1 : m_cnt - 16'd1;
         m_ctl = nctl;
         if (reg_wr && reg_addr == 2'd2) m_rel = reg_wdata;
         qe.push_front(ex_pin);  void'(qe.pop_back());
         qc.push_front(cnt_pin); void'(qc.pop_back());
      end
   end

   always @(negedge clk) begin
      if (rst_n) begin
         chk("cycle model count", count_o, m_cnt);
         chk("cycle model tog R7", tog_o, m_ctl[7]);
         chk("cycle model irq R9", irq_o, m_ctl[6] & m_ctl[4]);
      end
   end

   // ---------------- helpers ----------------
   task automatic chk(input string tag, input int act, input int exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [1:0] a, input logic [15:0] d);
      @(negedge clk);
      reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic rd(input logic [1:0] a, output logic [15:0] v);
      reg_addr = a;
      #1 v = reg_rdata;
   endtask

   task automatic cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic finish_run;
      $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      finish_run();
   end

   // ---------------- directed scenarios ----------------
   initial begin
      logic [15:0] v;
      logic        t0;
      cyc(3);
      rst_n = 1'b1;
      cyc(1);
      // R1 reset state
      chk("R1 count", count_o, 0);
      chk("R1 irq", irq_o, 0);
      chk("R1 tog", tog_o, 0);
      rd(2'd0, v); chk("R1 ctl", v, 0);
      rd(2'd2, v); chk("R1 reload", v, 0);

      // R3 up wrap, R7 toggle without irq
      wr(2'd2, 16'hFFF0);
      wr(2'd1, 16'hFFFD);
      wr(2'd0, C_RUN);
      tick_en = 1'b1; cyc(6); tick_en = 1'b0;
      chk("R3 count after up wrap", count_o, 16'hFFF3);
      rd(2'd0, v); chk("R3 flag set", v[6], 1);
      chk("R7 tog after one wrap", tog_o, 1);
      chk("R7 no irq from tog", irq_o, 0);

      // R9 irq follows flag and enable; software clear
      wr(2'd0, C_RUN | C_IEN | C_FLG | C_TOG);
      chk("R9 irq with flag and enable", irq_o, 1);
      wr(2'd0, C_RUN | C_IEN | C_TOG);
      chk("R9 irq after clear", irq_o, 0);

      // R2 freeze when stopped or capture selected
      wr(2'd0, C_TOG);
      tick_en = 1'b1; cyc(4);
      chk("R2 frozen when run=0", count_o, 16'hFFF3);
      wr(2'd0, C_RUN | C_CAP | C_TOG);
      cyc(3); tick_en = 1'b0;
      chk("R2 frozen with capture select", count_o, 16'hFFF3);

      // R4 down wrap at reload match
      ex_pin = 1'b0;
      wr(2'd2, 16'h0005);
      wr(2'd1, 16'h0008);
      wr(2'd0, C_RUN | C_DIR);
      tick_en = 1'b1; cyc(5); tick_en = 1'b0;
      chk("R4 count after down wrap", count_o, 16'hFFFE);
      rd(2'd0, v); chk("R4 flag set", v[6], 1);

      // R6 pin level selects up; R12 three-edge latency
      ex_pin = 1'b1; cyc(3);
      tick_en = 1'b1; cyc(1); tick_en = 1'b0;
      chk("R6 up count with pin high", count_o, 16'hFFFF);
      ex_pin = 1'b0; cyc(5);
      chk("R6 no reload on pin fall", count_o, 16'hFFFF);

      // R12: pin change seen only at the third edge
      ex_pin = 1'b1; tick_en = 1'b1; cyc(2); tick_en = 1'b0;
      chk("R12 old direction still in force", count_o, 16'hFFFD);
      cyc(2);

      // R5 pin reload
      wr(2'd0, C_RUN | C_XEN);
      wr(2'd2, 16'hABCD);
      wr(2'd1, 16'h1234);
      cyc(3);
      ex_pin = 1'b0; cyc(5);
      chk("R5 pin reload", count_o, 16'hABCD);
      rd(2'd0, v); chk("R5 flag untouched", v[6], 0);

      // R10 pin reload coinciding with up wrap
      ex_pin = 1'b1;
      wr(2'd2, 16'h2000);
      wr(2'd1, 16'hFFFF);
      cyc(3);
      t0 = tog_o;
      ex_pin = 1'b0; cyc(2);
      tick_en = 1'b1; cyc(1); tick_en = 1'b0;
      chk("R10 single reload", count_o, 16'h2000);
      chk("R10 toggle once", tog_o, !t0);
      rd(2'd0, v); chk("R10 flag set", v[6], 1);
      cyc(2);
      chk("R10 no second reload", count_o, 16'h2000);

      // R8 external count source, tick_en ignored
      wr(2'd0, C_RUN | C_SRC);
      wr(2'd1, 16'h0010);
      tick_en = 1'b1;
      for (int i = 0; i < 5; i++) begin
         cnt_pin = 1'b1; cyc(2);
         cnt_pin = 1'b0; cyc(2);
      end
      cyc(4); tick_en = 1'b0;
      chk("R8 counts pin falls", count_o, 16'h0015);

      // R11 software count write beats a tick
      wr(2'd0, C_RUN);
      tick_en = 1'b1;
      wr(2'd1, 16'h0100);
      #1 chk("R11 write wins", count_o, 16'h0100);
      tick_en = 1'b0;
      cyc(2);
      finish_run();
   end

endmodule